// File: doc/BRIEF.md
# Interlaced Field Line-Fetch Address Generator

This block turns one field of a progressive semi-planar YUV 4:2:0 frame into a sequence of memory line-read requests. It works with both interleaved chroma orders, CbCr and CrCb, because the chroma plane is read as whole lines and the byte order inside a line is left to the consumer. It supports unrotated fetching only. A start pulse latches the field parity, a stride-mode bit and the frame geometry. The block then emits one request per line on a valid/ready stream. Each request carries a start address, a byte length and a plane tag. A one-cycle done pulse marks the end of the field.

The stride-mode bit selects how the field is formed. With the bit set, the chroma container is twice as wide as the luma container. Every luma line and every chroma line is requested, and a later vertical halving stage builds the field. With the bit clear, only the luma lines of the selected parity are requested, while every chroma line is still read. The output is then 4:2:2 interlaced data.

Top module: `field_fetch_gen`

## Requirements
- R1: With stride mode 1, the luma requests are lines 0 to H-1 of the frame, in order. Line k has address luma_base + k*pitch.
- R2: With stride mode 1, the chroma requests are H/2 lines in order. Chroma line c has address chroma_base + c*2*pitch.
- R3: With stride mode 0, the luma requests cover only the lines whose parity matches the field select (0 = even: lines 0, 2, 4...; 1 = odd: lines 1, 3, 5...). Line k has address luma_base + k*pitch.
- R4: With stride mode 0, all H/2 chroma lines are requested for either field. Chroma line c has address chroma_base + c*pitch.
- R5: Requests alternate between planes, starting with luma. When one plane has no lines left, the remaining lines of the other plane follow in order. The plane tag is 0 for luma and 1 for chroma.
- R6: While valid is high and ready is low, the request's address, length and tag hold, and valid stays high.
- R7: Every request's length equals the line width latched at start, for both planes.
- R8: done is high for exactly one cycle, in the cycle after the last request is accepted. With H = 0, done is high in the cycle after start and no request is made.
- R9: A start pulse while a field is in progress has no effect on the requests being produced.
- R10: A start with an odd H raises err for the single cycle after start. No request and no done follow.
- R11: Addresses are computed modulo 2^32.
- R12: After reset, valid, done and err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a field when idle |
| field_odd_i | input | 1 | Field parity: 0 even, 1 odd |
| dbl_stride_i | input | 1 | Stride mode: 1 fetches all lines, 0 decimates luma |
| luma_base_i | input | 32 | Luma plane base address |
| chroma_base_i | input | 32 | Chroma plane base address |
| pitch_i | input | 32 | Byte distance between consecutive frame lines |
| width_i | input | LEN_W | Line length in bytes |
| height_i | input | 12 | Frame height in luma lines |
| req_valid_o | output | 1 | Request valid |
| req_ready_i | input | 1 | Request accepted when high with valid |
| req_addr_o | output | 32 | Request start address |
| req_len_o | output | LEN_W | Request byte length |
| req_chroma_o | output | 1 | Plane tag: 0 luma, 1 chroma |
| done_o | output | 1 | One-cycle end-of-field pulse |
| err_o | output | 1 | One-cycle odd-height error pulse |

## Verification
The bench uses the default widths: 32-bit addresses, 12-bit line counts and LEN_W = 16. It keeps heights small (0, 2, 6, 8, 10), so each field ends in a few dozen cycles, and it runs both modes and both parities. Base addresses are placed just below 2^32 so the address arithmetic wraps. Ready is driven always high, randomly, and mostly low, which covers hold behaviour and the leftover luma lines that stride mode 1 produces.

// File: rtl/ffg_pkg.sv
package ffg_pkg;
    localparam int unsigned ADDR_W = 32;
    localparam int unsigned CNT_W  = 12;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef struct packed {
        addr_t base;
        addr_t step;
        cnt_t  count;
    } plane_cfg_t;
endpackage

// File: rtl/ffg_field_plan.sv
module ffg_field_plan
    import ffg_pkg::*;
(
    input  logic       dbl_stride_i,
    input  logic       field_odd_i,
    input  addr_t      luma_base_i,
    input  addr_t      chroma_base_i,
    input  addr_t      pitch_i,
    input  cnt_t       height_i,
    output plane_cfg_t luma_cfg_o,
    output plane_cfg_t chroma_cfg_o,
    output logic       odd_height_o
);
    localparam int unsigned HALF_SH = 1;

    always_comb begin
        odd_height_o        = height_i[0];
        chroma_cfg_o.base   = chroma_base_i;
        chroma_cfg_o.count  = height_i >> HALF_SH;
        luma_cfg_o.step     = pitch_i;
        if (dbl_stride_i) begin
            luma_cfg_o.base    = luma_base_i;
            luma_cfg_o.count   = height_i;
            chroma_cfg_o.step  = pitch_i << HALF_SH;
        end else begin
            luma_cfg_o.base    = field_odd_i ? (luma_base_i + pitch_i) : luma_base_i;
            luma_cfg_o.step    = pitch_i << HALF_SH;
            luma_cfg_o.count   = height_i >> HALF_SH;
            chroma_cfg_o.step  = pitch_i;
        end
    end
endmodule

// File: rtl/ffg_plane_walker.sv
module ffg_plane_walker
    import ffg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  plane_cfg_t cfg_i,
    input  logic       adv_i,
    output addr_t      addr_o,
    output logic       pending_o
);
    typedef struct packed {
        addr_t addr;
        addr_t step;
        cnt_t  left;
    } walk_t;

    walk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.addr = cfg_i.base;
            st_d.step = cfg_i.step;
            st_d.left = cfg_i.count;
        end else if (adv_i) begin
            st_d.addr = st_q.addr + st_q.step;
            st_d.left = st_q.left - cnt_t'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o    = st_q.addr;
    assign pending_o = (st_q.left != '0);

    // R5: a plane is only stepped while it still owes lines
    assert_adv_only_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |-> pending_o);
    // R11: stepping adds the latched step modulo 2^32
    assert_step_wraps_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i) |=> (addr_o == $past(addr_o) + $past(st_q.step)));
endmodule

// File: rtl/field_fetch_gen.sv
module field_fetch_gen
    import ffg_pkg::*;
#(
    parameter int unsigned LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              field_odd_i,
    input  logic              dbl_stride_i,
    input  logic [ADDR_W-1:0] luma_base_i,
    input  logic [ADDR_W-1:0] chroma_base_i,
    input  logic [ADDR_W-1:0] pitch_i,
    input  logic [LEN_W-1:0]  width_i,
    input  logic [CNT_W-1:0]  height_i,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [LEN_W-1:0]  req_len_o,
    output logic              req_chroma_o,
    output logic              done_o,
    output logic              err_o
);
    localparam int unsigned NPLANE = 2;
    localparam int unsigned PL_LUMA = 0;
    localparam int unsigned PL_CHROMA = 1;

    typedef struct packed {
        logic             busy;
        logic             pref_chroma;
        logic             err;
        logic [LEN_W-1:0] len;
    } top_st_t;

    top_st_t st_d, st_q;

    plane_cfg_t cfg   [NPLANE];
    addr_t      paddr [NPLANE];
    logic       pend  [NPLANE];
    logic       adv   [NPLANE];
    logic       odd_height, start_ok, load, sel_chroma, fire;

    ffg_field_plan u_plan (
        .dbl_stride_i  (dbl_stride_i),
        .field_odd_i   (field_odd_i),
        .luma_base_i   (luma_base_i),
        .chroma_base_i (chroma_base_i),
        .pitch_i       (pitch_i),
        .height_i      (height_i),
        .luma_cfg_o    (cfg[PL_LUMA]),
        .chroma_cfg_o  (cfg[PL_CHROMA]),
        .odd_height_o  (odd_height)
    );

    for (genvar p = 0; p < NPLANE; p++) begin : g_walk
        ffg_plane_walker u_walk (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_i    (load),
            .cfg_i     (cfg[p]),
            .adv_i     (adv[p]),
            .addr_o    (paddr[p]),
            .pending_o (pend[p])
        );
    end

    always_comb begin
        start_ok    = start_i && !st_q.busy;
        load        = start_ok && !odd_height;
        sel_chroma  = pend[PL_CHROMA] && (st_q.pref_chroma || !pend[PL_LUMA]);
        req_valid_o = st_q.busy && (pend[PL_LUMA] || pend[PL_CHROMA]);
        fire        = req_valid_o && req_ready_i;
        done_o      = st_q.busy && !pend[PL_LUMA] && !pend[PL_CHROMA];
        adv[PL_LUMA]   = fire && !sel_chroma;
        adv[PL_CHROMA] = fire && sel_chroma;

        st_d     = st_q;
        st_d.err = start_ok && odd_height;
        if (load) begin
            st_d.busy        = 1'b1;
            st_d.pref_chroma = 1'b0;
            st_d.len         = width_i;
        end
        if (done_o) st_d.busy = 1'b0;
        if (fire)   st_d.pref_chroma = !sel_chroma;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_addr_o   = sel_chroma ? paddr[PL_CHROMA] : paddr[PL_LUMA];
    assign req_len_o    = st_q.len;
    assign req_chroma_o = sel_chroma;
    assign err_o        = st_q.err;

    // R6: a stalled request keeps its contents
    assert_hold_stalled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o)
            && $stable(req_chroma_o) && $stable(req_len_o)));
    // R5: an accepted luma line is followed by chroma while chroma remains
    assert_alternate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !req_chroma_o && pend[PL_CHROMA]) |=> (req_valid_o && req_chroma_o));
    // R8: done lasts a single cycle
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R9: a start during a field leaves the latched length untouched
    assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && start_i) |=> $stable(req_len_o));
    // R10: an odd-height start produces neither requests nor done
    assert_err_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!req_valid_o && !done_o));
    // R12: idle after reset
    assert_reset_idle_R12: assert property (@(posedge clk)
        $rose(rst_n) |-> (!req_valid_o && !done_o && !err_o));
endmodule

// File: tb/field_fetch_gen_test.sv
module field_fetch_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 16;

    typedef struct packed {
        logic [31:0] addr;
        logic        ch;
    } exp_t;

    logic clk = 0, rst_n = 0;
    logic start_i = 0, field_odd_i = 0, dbl_stride_i = 0, req_ready_i = 0;
    logic [31:0] luma_base_i = 0, chroma_base_i = 0, pitch_i = 0;
    logic [LEN_W-1:0] width_i = 0;
    logic [11:0] height_i = 0;
    logic req_valid_o, req_chroma_o, done_o, err_o;
    logic [31:0] req_addr_o;
    logic [LEN_W-1:0] req_len_o;

    field_fetch_gen #(.LEN_W(LEN_W)) uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int vectors = 0, errors = 0;
    int ready_mode = 0;
    string tag = "R12";
    exp_t q[$];
    bit m_busy = 0, m_err = 0;
    logic [LEN_W-1:0] m_len = 0;

    task automatic report(string req, string what, longint act, longint exp);
        errors++;
        $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    endtask

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    function automatic void build(bit dbl, bit odd, logic [31:0] lb, logic [31:0] cb,
                                  logic [31:0] pt, int h);
        logic [31:0] la[$];
        logic [31:0] ca[$];
        bit pref = 0;
        q.delete();
        for (int k = 0; k < h; k++)
            if (dbl || (k % 2) == int'(odd)) la.push_back(lb + 32'(k) * pt);
        for (int c = 0; c < h / 2; c++)
            ca.push_back(cb + 32'(c) * (dbl ? pt * 2 : pt));
        while (la.size() > 0 || ca.size() > 0) begin
            if (ca.size() > 0 && (pref || la.size() == 0)) begin
                q.push_back('{addr: ca.pop_front(), ch: 1'b1});
                pref = 0;
            end else begin
                q.push_back('{addr: la.pop_front(), ch: 1'b0});
                pref = 1;
            end
        end
    endfunction

    // reference model, advances on each rising edge
    always @(posedge clk) begin
        if (rst_n) begin
            m_err = 0;
            if (m_busy) begin
                if (q.size() == 0) m_busy = 0;
                else if (req_ready_i) void'(q.pop_front());
            end else if (start_i) begin
                if (height_i[0]) m_err = 1;
                else begin
                    build(dbl_stride_i, field_odd_i, luma_base_i, chroma_base_i,
                          pitch_i, int'(height_i));
                    m_len = width_i;
                    m_busy = 1;
                end
            end
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit ev;
            vectors++;
            ev = m_busy && q.size() > 0;
            if (req_valid_o !== ev) report(tag, "valid", req_valid_o, ev);
            if (done_o !== (m_busy && q.size() == 0)) report("R8", "done", done_o, m_busy && q.size() == 0);
            if (err_o !== m_err) report("R10", "err", err_o, m_err);
            if (ev && req_valid_o === 1'b1) begin
                if (req_addr_o !== q[0].addr) report(tag, "addr", req_addr_o, q[0].addr);
                if (req_chroma_o !== q[0].ch) report("R5", "plane", req_chroma_o, q[0].ch);
                if (req_len_o !== m_len) report("R7", "len", req_len_o, m_len);
            end
            case (ready_mode)
                0: req_ready_i <= 1'b1;
                1: req_ready_i <= 1'($urandom_range(1));
                default: req_ready_i <= ($urandom_range(3) == 0);
            endcase
        end
    end

    task automatic run(string t, int rmode, bit dbl, bit odd, logic [31:0] lb,
                       logic [31:0] cb, logic [31:0] pt, logic [LEN_W-1:0] w,
                       int h, bit intrude);
        tag = t;
        ready_mode = rmode;
        @(negedge clk);
        dbl_stride_i = dbl; field_odd_i = odd; luma_base_i = lb;
        chroma_base_i = cb; pitch_i = pt; width_i = w; height_i = 12'(h);
        start_i = 1;
        @(negedge clk);
        start_i = 0;
        if (intrude) begin
            repeat (3) @(negedge clk);
            // R9: second start while busy, different geometry
            luma_base_i = 32'h5555_0000; width_i = 16'h0777; height_i = 12'd4;
            dbl_stride_i = !dbl; field_odd_i = !odd; start_i = 1;
            @(negedge clk);
            start_i = 0;
        end
        while (m_busy || m_err) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: idle state while and right after reset
        vectors++;
        if (req_valid_o !== 1'b0 || done_o !== 1'b0 || err_o !== 1'b0)
            report("R12", "reset outputs", {req_valid_o, done_o, err_o}, 0);
        rst_n = 1;
        // R1 R2 R5: stride mode 1, luma remainder after chroma runs out
        run("R1 R2 R5", 0, 1, 0, 32'h1000_0000, 32'h2000_0000, 32'd640, 16'd640, 8, 0);
        run("R1 R2 R6", 2, 1, 1, 32'h1000_0000, 32'h2000_0000, 32'd256, 16'd200, 6, 0);
        // R3 R4: stride mode 0 both parities
        run("R3 R4 R5", 0, 0, 0, 32'h0000_4000, 32'h0008_0000, 32'd128, 16'd96, 8, 0);
        run("R3 R4 R6", 1, 0, 1, 32'h0000_4000, 32'h0008_0000, 32'd128, 16'd96, 10, 0);
        // R6: heavy backpressure
        run("R3 R6", 2, 0, 1, 32'h0300_0000, 32'h0400_0000, 32'd64, 16'd64, 6, 0);
        // R11: wrap past 2^32
        run("R1 R11", 1, 1, 0, 32'hFFFF_FF00, 32'hFFFF_FFC0, 32'h80, 16'h80, 8, 0);
        run("R3 R11", 1, 0, 1, 32'hFFFF_FF80, 32'hFFFF_FFF0, 32'h40, 16'h40, 6, 0);
        // R8: zero-height field and shortest field
        run("R8", 0, 0, 0, 32'h100, 32'h200, 32'd16, 16'd16, 0, 0);
        run("R8 R2", 2, 1, 1, 32'h100, 32'h200, 32'd16, 16'd16, 2, 0);
        // R10: odd height
        run("R10", 0, 1, 0, 32'h100, 32'h200, 32'd16, 16'd16, 7, 0);
        run("R10", 1, 0, 1, 32'h100, 32'h200, 32'd16, 16'd16, 1, 0);
        // R9: start while busy ignored
        run("R9", 1, 1, 0, 32'h0A00_0000, 32'h0B00_0000, 32'd320, 16'd300, 8, 1);
        run("R9 R4", 2, 0, 0, 32'h0A00_0000, 32'h0B00_0000, 32'd320, 16'd300, 8, 1);
        finish_up();
    end
endmodule